// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block sits between a peripheral's register write bus and its protected register file. It holds two 32-bit key registers. Writes to the protected registers are allowed only while both keys hold their magic values. Software opens the gate by writing the first key and then the second. It closes the gate by writing zero to both keys. Any other value written to either key also closes the gate at once.

For every write the block produces a qualified write enable that the protected registers use in place of the raw bus strobe. When a write to a protected address arrives while the gate is closed, the block drops that write. It signals the drop for one cycle and sets a sticky violation flag. The key registers and the violation flag register are never protected. A read port returns the stored keys and the flag, and no read is ever gated by the lock state.

Top module: `wp_unlock_gate`

## Requirements
- R1: After reset both key registers hold zero, `unlocked_o` is 0 and `viol_o` is 0.
- R2: Key A at offset 0x6C and key B at offset 0x70 are 32-bit registers. They accept every write whatever the lock state, and `rd_data_o` returns their stored value when `rd_addr_i` selects them.
- R3: `unlocked_o` is 1 exactly when key A holds 0x83E70B13 and key B holds 0x95A4F1E0. Writing key A and then key B unlocks the gate, and `unlocked_o` rises in the cycle after the second key write. Because only the stored values count, writing the keys in the opposite order also unlocks.
- R4: A write of any non-magic value to either key locks the gate from the next cycle on.
- R5: Writing zero to key A and zero to key B leaves the gate locked.
- R6: Every address other than 0x6C, 0x70 and 0x78 is protected. `prot_we_o` is 1 in the same cycle as a write to a protected address made while unlocked, and 0 in every other cycle.
- R7: A write to a protected address made while locked leaves `prot_we_o` at 0 and raises `locked_wr_o` for that cycle. `locked_wr_o` is 0 in every other cycle.
- R8: A dropped write sets `viol_o` in the next cycle. The flag stays set until a write to offset 0x78 with data bit 0 equal to 1 clears it. A write to 0x78 with bit 0 equal to 0 leaves it unchanged. The flag reads back as bit 0 of `rd_data_o` at 0x78, with the upper bits zero.
- R9: The read path ignores the lock state. Any address other than 0x6C, 0x70 and 0x78 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register bus write strobe |
| wr_addr_i | input | 8 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte offset |
| rd_data_o | output | 32 | Read data for the keys and the violation flag |
| prot_we_o | output | 1 | Qualified write enable for protected registers |
| locked_wr_o | output | 1 | Protected write dropped this cycle |
| unlocked_o | output | 1 | Both keys currently match |
| viol_o | output | 1 | Sticky violation flag |

## Verification
The assertions check on every cycle that a qualified enable never appears without an unlocked gate and a bus write. They also check that a pass and a drop never coincide, that a dropped write always leaves the flag set, that the flag never clears without its clear write, that a bad key value always locks, and that the lock state moves only on writes. Only the bench scenarios can show the actual magic values, the unlock order and its timing, the readback contents, the reverse-order unlock and the effect of reset arriving mid-session.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ADDR_W   = 8;
  localparam int KEY_W    = 32;
  localparam int NUM_KEYS = 2;

  localparam int KEY_OFS [NUM_KEYS] = '{32'h6C, 32'h70};
  localparam logic [31:0] KEY_MAGIC [NUM_KEYS] = '{32'h83E7_0B13, 32'h95A4_F1E0};
  localparam int VIOL_OFS = 32'h78;
endpackage

// File: rtl/wp_key_slot.sv
module wp_key_slot #(
  parameter int          ADDR_W = 8,
  parameter int          KEY_W  = 32,
  parameter int          OFS    = 0,
  parameter logic [31:0] MAGIC  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0]  wr_data_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              hit_o,
  output logic              match_o
);
  localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(OFS);
  localparam logic [KEY_W-1:0]  MY_KEY = KEY_W'(MAGIC);

  logic [KEY_W-1:0] key_q;

  assign hit_o = (wr_addr_i == MY_OFS);

  // key slots are never write-protected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                key_q <= '0;
    else if (wr_en_i && hit_o)  key_q <= wr_data_i;
  end

  assign key_o   = key_q;
  assign match_o = (key_q == MY_KEY);
endmodule

// File: rtl/wp_viol_flag.sv
module wp_viol_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
  import wp_pkg::*;
#(
  parameter int AW = wp_pkg::ADDR_W,
  parameter int DW = wp_pkg::KEY_W,
  parameter int NK = wp_pkg::NUM_KEYS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          prot_we_o,
  output logic          locked_wr_o,
  output logic          unlocked_o,
  output logic          viol_o
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(VIOL_OFS);

  logic [DW-1:0] key_w [NK];
  logic [NK-1:0] hit_w;
  logic [NK-1:0] match_w;

  for (genvar k = 0; k < NK; k++) begin : g_key
    wp_key_slot #(
      .ADDR_W (AW),
      .KEY_W  (DW),
      .OFS    (KEY_OFS[k]),
      .MAGIC  (KEY_MAGIC[k])
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .key_o     (key_w[k]),
      .hit_o     (hit_w[k]),
      .match_o   (match_w[k])
    );
  end

  logic stat_hit, prot_hit, open_w;

  assign stat_hit = (wr_addr_i == STAT_ADDR);
  assign prot_hit = ~(|hit_w) & ~stat_hit;
  assign open_w   = &match_w;

  assign prot_we_o   = wr_en_i & prot_hit &  open_w;
  assign locked_wr_o = wr_en_i & prot_hit & ~open_w;
  assign unlocked_o  = open_w;

  wp_viol_flag u_viol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (locked_wr_o),
    .clr_i  (wr_en_i & stat_hit & wr_data_i[0]),
    .flag_o (viol_o)
  );

  // read path: independent of lock state
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == STAT_ADDR) rd_data_o = DW'(viol_o);
    for (int k = 0; k < NK; k++) begin
      if (rd_addr_i == AW'(KEY_OFS[k])) rd_data_o = key_w[k];
    end
  end
endmodule

// File: rtl/wp_unlock_gate_chk.sv
module wp_unlock_gate_chk
  import wp_pkg::*;
#(
  parameter int AW = wp_pkg::ADDR_W,
  parameter int DW = wp_pkg::KEY_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          prot_we_o,
  input logic          locked_wr_o,
  input logic          unlocked_o,
  input logic          viol_o
);
  localparam logic [AW-1:0] A0 = AW'(KEY_OFS[0]);
  localparam logic [AW-1:0] A1 = AW'(KEY_OFS[1]);
  localparam logic [AW-1:0] AS = AW'(VIOL_OFS);
  localparam logic [DW-1:0] M0 = DW'(KEY_MAGIC[0]);
  localparam logic [DW-1:0] M1 = DW'(KEY_MAGIC[1]);

  assert_we_needs_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_we_o |-> (unlocked_o && wr_en_i));

  assert_pass_xor_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prot_we_o && locked_wr_o));

  assert_drop_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_wr_o |=> viol_o);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !(wr_en_i && wr_addr_i == AS && wr_data_i[0])) |=> viol_o);

  assert_bad_key_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A0 && wr_data_i != M0) |=> !unlocked_o);

  assert_bad_key_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A1 && wr_data_i != M1) |=> !unlocked_o);

  assert_lock_moves_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(unlocked_o));
endmodule

bind wp_unlock_gate wp_unlock_gate_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .prot_we_o   (prot_we_o),
  .locked_wr_o (locked_wr_o),
  .unlocked_o  (unlocked_o),
  .viol_o      (viol_o)
);

// File: tb/tb_wp_unlock_gate.sv
module tb_wp_unlock_gate;
  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        pwe;
    logic        lwr;
    logic        unl;
    logic        vio;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h10, 32'h5,          1'b0, 1'b1, 1'b0, 1'b1}, // locked write dropped
    '{1'b1, 8'h78, 32'h1,          1'b0, 1'b0, 1'b0, 1'b0}, // clear flag
    '{1'b1, 8'h6C, KA,             1'b0, 1'b0, 1'b0, 1'b0}, // key A
    '{1'b1, 8'h70, KB,             1'b0, 1'b0, 1'b1, 1'b0}, // key B -> open
    '{1'b1, 8'h10, 32'hAA,         1'b1, 1'b0, 1'b1, 1'b0}, // passes
    '{1'b0, 8'h10, 32'hAA,         1'b0, 1'b0, 1'b1, 1'b0}, // idle
    '{1'b1, 8'h70, 32'h95A4_F1E1,  1'b0, 1'b0, 1'b0, 1'b0}, // R4 bad key B
    '{1'b1, 8'h20, 32'h1,          1'b0, 1'b1, 1'b0, 1'b1}, // dropped
    '{1'b1, 8'h70, KB,             1'b0, 1'b0, 1'b1, 1'b1}, // reopen, flag sticky
    '{1'b1, 8'h00, 32'h3,          1'b1, 1'b0, 1'b1, 1'b1}, // offset 0 protected
    '{1'b1, 8'h6C, 32'h0,          1'b0, 1'b0, 1'b0, 1'b1}, // R5 zero key A
    '{1'b1, 8'h70, 32'h0,          1'b0, 1'b0, 1'b0, 1'b1}, // R5 zero key B
    '{1'b1, 8'h78, 32'hFFFF_FFFE,  1'b0, 1'b0, 1'b0, 1'b1}, // bit0=0 keeps flag
    '{1'b1, 8'h78, 32'h1,          1'b0, 1'b0, 1'b0, 1'b0}  // clear
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        prot_we_o, locked_wr_o, unlocked_o, viol_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  wp_unlock_gate dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .prot_we_o   (prot_we_o),
    .locked_wr_o (locked_wr_o),
    .unlocked_o  (unlocked_o),
    .viol_o      (viol_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_addr_i = a;
    #1;
    chk(rd_data_o, exp, tag);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #20;
    chk(32'(unlocked_o), 0, "R1 unlocked in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(32'(unlocked_o), 0, "R1 unlocked after reset");
    chk(32'(viol_o), 0, "R1 viol after reset");
    rd(8'h6C, 0, "R1 key A zero");
    rd(8'h70, 0, "R1 key B zero");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i = VEC[i].we; wr_addr_i = VEC[i].addr; wr_data_i = VEC[i].data;
      #1;
      chk(32'(prot_we_o), 32'(VEC[i].pwe), $sformatf("R6 prot_we vec %0d", i));
      chk(32'(locked_wr_o), 32'(VEC[i].lwr), $sformatf("R7 locked_wr vec %0d", i));
      @(posedge clk_i);
      #1;
      chk(32'(unlocked_o), 32'(VEC[i].unl), $sformatf("R3 unlocked vec %0d", i));
      chk(32'(viol_o), 32'(VEC[i].vio), $sformatf("R8 viol vec %0d", i));
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;

    // R2: keys writable and readable while locked
    wr(8'h70, 32'h1234_5678);
    rd(8'h70, 32'h1234_5678, "R2 key B readback locked");
    chk(32'(unlocked_o), 0, "R4 odd key B keeps locked");

    // R3: reverse order still opens
    wr(8'h70, KB);
    chk(32'(unlocked_o), 0, "R3 only key B not open");
    wr(8'h6C, KA);
    chk(32'(unlocked_o), 1, "R3 reverse order opens");
    rd(8'h6C, KA, "R2 key A readback open");
    rd(8'h70, KB, "R9 read unaffected by lock");

    // R8 readback and R9 unmapped reads
    wr(8'h6C, 32'h0);
    wr(8'h44, 32'h7);
    rd(8'h78, 32'h1, "R8 flag readback");
    rd(8'h44, 32'h0, "R9 unmapped reads zero");
    chk(32'(unlocked_o), 0, "R4 key A cleared locks");

    // R1: reset mid-session
    wr(8'h6C, KA);
    chk(32'(unlocked_o), 1, "R3 reopened");
    rst_ni = 1'b0;
    #1;
    chk(32'(unlocked_o), 0, "R1 async reset locks");
    rd(8'h6C, 0, "R1 key A cleared by reset");
    chk(32'(viol_o), 0, "R1 reset clears flag");
    rst_ni = 1'b1;

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule